// File: doc/BRIEF.md
# Windowed Watchdog Timer with Postscaler

This block is a watchdog counter advanced by a slow low-power tick strobe that arrives on the system clock. Its time-out length is a base period (a parameter number of ticks) multiplied by a power of two picked by a 5-bit postscaler code taken from a configuration strap. If software does not service it in time, the counter expires. Expiry raises a device reset request when the device is awake. When the device is in sleep or idle, expiry raises a non-maskable wake event instead.

An optional window mode narrows the moment at which servicing is legal. In that mode a clear is accepted only in the final fraction of the period. The fraction comes from a 2-bit strap. A clear that arrives before the window opens is treated as a fault and requests a reset at once. Enable and window mode can each be forced by a strap. Otherwise each follows a software bit held inside the block. A debug indication freezes the count. Debug clear commands and wake-by-interrupt pulses restart the count from zero.

Top module: `wdg_top`

## Requirements
- R1: For a postscaler code c not above PS_MAX (default 20), a time-out occurs exactly TICKS_PER_BASE * 2^c ticks after the counter was last zeroed.
- R2: Any postscaler code above PS_MAX gives the same period as PS_MAX.
- R3: Window size code 2'b11, 2'b10, 2'b01 and 2'b00 opens a window of 2/8, 3/8, 4/8 and 6/8 of the period respectively. The window opens when the count reaches period minus period*eighths/8. In window mode a clear at or after that count is accepted silently and zeroes the counter.
- R4: In window mode, a clear while the count is below the threshold gives a one-cycle pulse on both `win_err_o` and `rst_req_o` in the cycle after the clear, and zeroes the counter.
- R5: Outside window mode, a clear at any count zeroes the counter and produces no pulse.
- R6: On expiry while awake, `timeout_o` and `rst_req_o` pulse for one cycle, `nmi_o` stays low, and the counter restarts from 0.
- R7: On expiry while `sleep_i` or `idle_i` is high, `timeout_o` and `nmi_o` pulse for one cycle and `rst_req_o` stays low.
- R8: The counter is zeroed by reset, `clr_i`, `dbg_clr_i` and `irq_wake_i`. Raising `sleep_i` or `idle_i` does not alter the count.
- R9: With `strap_force_en_i` high, `en_o` reads 1 and a software write of 0 to the enable bit has no effect.
- R10: The software enable bit resets to 0. While the watchdog is disabled, the counter stays at 0 and no pulse is raised.
- R11: `win_mode_o` is 1 when `strap_win_en_i` is high. Otherwise it follows the software window bit, which resets to 0 and is written by `cfg_we_i` with `cfg_win_i`.
- R12: While `debug_i` is high and no clear arrives, the count holds and no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| tick_i | input | 1 | Low-power tick strobe, one clock wide per tick |
| strap_force_en_i | input | 1 | Strap forcing the watchdog on |
| strap_win_en_i | input | 1 | Strap forcing window mode on |
| strap_win_size_i | input | 2 | Window size code |
| strap_ps_i | input | 5 | Postscaler code |
| cfg_we_i | input | 1 | Write strobe for the software bits |
| cfg_on_i | input | 1 | Software enable value to write |
| cfg_win_i | input | 1 | Software window-mode value to write |
| clr_i | input | 1 | Software service (clear) strobe |
| sleep_i | input | 1 | Device is in sleep |
| idle_i | input | 1 | Device is in idle |
| debug_i | input | 1 | Debug halt active |
| dbg_clr_i | input | 1 | Debug clear command |
| irq_wake_i | input | 1 | Wake from sleep or idle by an interrupt |
| en_o | output | 1 | Watchdog enabled (strap or software) |
| win_mode_o | output | 1 | Window mode in force |
| count_o | output | CNT_W | Current tick count |
| timeout_o | output | 1 | One-cycle expiry pulse |
| rst_req_o | output | 1 | One-cycle device reset request |
| nmi_o | output | 1 | One-cycle non-maskable wake event |
| win_err_o | output | 1 | One-cycle early-clear fault pulse |

## Verification
The assertions assume that the straps and the tick parameter keep the period at two or more ticks, so that two expiries can never fall on adjacent cycles. They also assume that the straps change only while reset is held, since the count is compared against a period derived from them. The stimulus changes straps only inside a reset pulse, and it uses a short base period and a small PS_MAX so that every postscaler code and every window size can be swept. It holds the tick high for the whole run, so every clock is one tick.

// File: rtl/wdg_pkg.sv
// Package wdg_pkg: shared constants and helpers for the watchdog.
// Assumes the postscaler code is 5 bits wide and the window code 2 bits.
package wdg_pkg;
    localparam int PS_W  = 5;
    localparam int WIN_W = 2;

    // Window size in eighths of the period for each window code.
    function automatic logic [2:0] win_eighths(input logic [WIN_W-1:0] code);
        case (code)
            2'b11:   win_eighths = 3'd2;
            2'b10:   win_eighths = 3'd3;
            2'b01:   win_eighths = 3'd4;
            default: win_eighths = 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/wdg_limits.sv
// Module wdg_limits: turns the postscaler and window straps into the last
// count of the period and the count at which the service window opens.
// Assumes TICKS_PER_BASE >= 2 and PS_MAX < 2**PS_W.
module wdg_limits
    import wdg_pkg::*;
#(
    parameter int TICKS_PER_BASE = 32,
    parameter int PS_MAX         = 20,
    parameter int CNT_W          = 26
) (
    input  logic [PS_W-1:0]  ps_code_i,
    input  logic [WIN_W-1:0] win_size_i,
    output logic [CNT_W-1:0] last_o,
    output logic [CNT_W-1:0] thr_o
);
    localparam int WIDE_W = CNT_W + 3;
    localparam logic [PS_W-1:0] PS_CAP = PS_W'(PS_MAX);

    logic [PS_W-1:0]   ps_eff;
    logic [WIDE_W-1:0] period_w;
    logic [WIDE_W-1:0] win_len_w;

    // Clamp the code, build the period and the window threshold.
    always_comb begin
        ps_eff    = (ps_code_i > PS_CAP) ? PS_CAP : ps_code_i;
        period_w  = WIDE_W'(TICKS_PER_BASE) << ps_eff;
        win_len_w = (period_w * WIDE_W'(win_eighths(win_size_i))) >> 3;
        last_o    = CNT_W'(period_w - WIDE_W'(1));
        thr_o     = CNT_W'(period_w - win_len_w);
    end
endmodule

// File: rtl/wdg_counter.sv
// Module wdg_counter: the tick counter with clear, hold and window logic.
// Flags expiry and early-clear faults combinationally for the event stage.
// Assumes last_i >= 1 and thr_i <= last_i.
module wdg_counter #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             win_mode_i,
    input  logic             clr_i,
    input  logic             dbg_clr_i,
    input  logic             irq_wake_i,
    input  logic             debug_i,
    input  logic [CNT_W-1:0] last_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o,
    output logic             viol_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             win_open;
    logic             any_clr;

    // Decide this cycle's fault, expiry and clear conditions.
    always_comb begin
        win_open = (cnt_q >= thr_i);
        viol_o   = en_i && win_mode_i && clr_i && !win_open;
        any_clr  = clr_i || dbg_clr_i || irq_wake_i;
        expire_o = en_i && tick_i && !debug_i && !any_clr && (cnt_q == last_i);
    end

    // Advance, hold or zero the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || any_clr || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i && !debug_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/wdg_event.sv
// Module wdg_event: registers one-cycle output pulses and routes an expiry
// to a reset request or a non-maskable wake according to power mode.
// Assumes expire_i and viol_i are single-cycle conditions.
module wdg_event (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic viol_i,
    input  logic sleep_i,
    input  logic idle_i,
    output logic timeout_o,
    output logic rst_req_o,
    output logic nmi_o,
    output logic win_err_o
);
    logic low_pwr;

    // Any power-saving mode turns an expiry into a wake event.
    assign low_pwr = sleep_i || idle_i;

    // Register the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_o <= 1'b0;
            rst_req_o <= 1'b0;
            nmi_o     <= 1'b0;
            win_err_o <= 1'b0;
        end else begin
            timeout_o <= expire_i;
            rst_req_o <= (expire_i && !low_pwr) || viol_i;
            nmi_o     <= expire_i && low_pwr;
            win_err_o <= viol_i;
        end
    end
endmodule

// File: rtl/wdg_top.sv
// Module wdg_top: windowed watchdog with postscaler. Holds the software
// enable and window bits, and joins the limit, counter and event stages.
// Assumes straps are stable outside reset and TICKS_PER_BASE >= 2.
module wdg_top
    import wdg_pkg::*;
#(
    parameter int TICKS_PER_BASE = 32,
    parameter int PS_MAX         = 20,
    parameter int CNT_W          = $clog2(TICKS_PER_BASE) + PS_MAX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             strap_force_en_i,
    input  logic             strap_win_en_i,
    input  logic [1:0]       strap_win_size_i,
    input  logic [4:0]       strap_ps_i,
    input  logic             cfg_we_i,
    input  logic             cfg_on_i,
    input  logic             cfg_win_i,
    input  logic             clr_i,
    input  logic             sleep_i,
    input  logic             idle_i,
    input  logic             debug_i,
    input  logic             dbg_clr_i,
    input  logic             irq_wake_i,
    output logic             en_o,
    output logic             win_mode_o,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o,
    output logic             rst_req_o,
    output logic             nmi_o,
    output logic             win_err_o
);
    logic             sw_on_q;
    logic             sw_win_q;
    logic [CNT_W-1:0] last_w;
    logic [CNT_W-1:0] thr_w;
    logic             expire_w;
    logic             viol_w;

    // Software enable and window bits, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_on_q  <= 1'b0;
            sw_win_q <= 1'b0;
        end else if (cfg_we_i) begin
            sw_on_q  <= cfg_on_i;
            sw_win_q <= cfg_win_i;
        end
    end

    // Straps override the software bits.
    assign en_o       = strap_force_en_i || sw_on_q;
    assign win_mode_o = strap_win_en_i || sw_win_q;

    wdg_limits #(
        .TICKS_PER_BASE (TICKS_PER_BASE),
        .PS_MAX         (PS_MAX),
        .CNT_W          (CNT_W)
    ) limits_i (
        .ps_code_i  (strap_ps_i),
        .win_size_i (strap_win_size_i),
        .last_o     (last_w),
        .thr_o      (thr_w)
    );

    wdg_counter #(
        .CNT_W (CNT_W)
    ) counter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .en_i       (en_o),
        .win_mode_i (win_mode_o),
        .clr_i      (clr_i),
        .dbg_clr_i  (dbg_clr_i),
        .irq_wake_i (irq_wake_i),
        .debug_i    (debug_i),
        .last_i     (last_w),
        .thr_i      (thr_w),
        .count_o    (count_o),
        .expire_o   (expire_w),
        .viol_o     (viol_w)
    );

    wdg_event event_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire_w),
        .viol_i    (viol_w),
        .sleep_i   (sleep_i),
        .idle_i    (idle_i),
        .timeout_o (timeout_o),
        .rst_req_o (rst_req_o),
        .nmi_o     (nmi_o),
        .win_err_o (win_err_o)
    );
endmodule

// File: rtl/wdg_top_chk.sv
// Module wdg_top_chk: assertion checker bound to wdg_top.
// Assumes straps stay stable outside reset.
module wdg_top_chk #(
    parameter int CNT_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             sleep_i,
    input logic             idle_i,
    input logic             debug_i,
    input logic             dbg_clr_i,
    input logic             irq_wake_i,
    input logic             en_o,
    input logic             win_mode_o,
    input logic [CNT_W-1:0] count_o,
    input logic             timeout_o,
    input logic             rst_req_o,
    input logic             nmi_o,
    input logic             win_err_o
);
    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o); // R6
    AST_TIMEOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> count_o == '0); // R6
    AST_NMI_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> !rst_req_o && timeout_o); // R7
    AST_WINERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_mode_o && clr_i) |=> (win_err_o == rst_req_o) || timeout_o); // R4
    AST_WINERR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        win_err_o |-> rst_req_o && count_o == '0); // R4
    AST_NOWIN_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        !win_mode_o |=> !win_err_o); // R5
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> count_o == '0 && !timeout_o); // R10
    AST_DEBUG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_i && en_o && !clr_i && !dbg_clr_i && !irq_wake_i)
        |=> $stable(count_o) && !timeout_o); // R12
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_clr_i || irq_wake_i) |=> count_o == '0); // R8
endmodule

bind wdg_top wdg_top_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .sleep_i    (sleep_i),
    .idle_i     (idle_i),
    .debug_i    (debug_i),
    .dbg_clr_i  (dbg_clr_i),
    .irq_wake_i (irq_wake_i),
    .en_o       (en_o),
    .win_mode_o (win_mode_o),
    .count_o    (count_o),
    .timeout_o  (timeout_o),
    .rst_req_o  (rst_req_o),
    .nmi_o      (nmi_o),
    .win_err_o  (win_err_o)
);

// File: tb/wdg_top_tb_top.sv
// Bench wdg_top_tb_top: sweeps every postscaler and window code of a
// shortened watchdog and checks periods, windows and events arithmetically.
module wdg_top_tb_top;
    localparam int TPB   = 4;
    localparam int PSMAX = 4;
    localparam int CW    = $clog2(TPB) + PSMAX + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b1;
    logic          strap_force_en_i = 1'b1;
    logic          strap_win_en_i = 1'b0;
    logic [1:0]    strap_win_size_i = 2'b00;
    logic [4:0]    strap_ps_i = 5'd0;
    logic          cfg_we_i = 1'b0;
    logic          cfg_on_i = 1'b0;
    logic          cfg_win_i = 1'b0;
    logic          clr_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic          idle_i = 1'b0;
    logic          debug_i = 1'b0;
    logic          dbg_clr_i = 1'b0;
    logic          irq_wake_i = 1'b0;
    logic          en_o;
    logic          win_mode_o;
    logic [CW-1:0] count_o;
    logic          timeout_o;
    logic          rst_req_o;
    logic          nmi_o;
    logic          win_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    wdg_top #(.TICKS_PER_BASE(TPB), .PS_MAX(PSMAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .strap_force_en_i(strap_force_en_i), .strap_win_en_i(strap_win_en_i),
        .strap_win_size_i(strap_win_size_i), .strap_ps_i(strap_ps_i),
        .cfg_we_i(cfg_we_i), .cfg_on_i(cfg_on_i), .cfg_win_i(cfg_win_i),
        .clr_i(clr_i), .sleep_i(sleep_i), .idle_i(idle_i), .debug_i(debug_i),
        .dbg_clr_i(dbg_clr_i), .irq_wake_i(irq_wake_i), .en_o(en_o),
        .win_mode_o(win_mode_o), .count_o(count_o), .timeout_o(timeout_o),
        .rst_req_o(rst_req_o), .nmi_o(nmi_o), .win_err_o(win_err_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog on the bench itself.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        steps(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1;
        step();
        clr_i = 1'b0;
    endtask

    task automatic write_cfg(input logic on, input logic win);
        cfg_on_i = on;
        cfg_win_i = win;
        cfg_we_i = 1'b1;
        step();
        cfg_we_i = 1'b0;
    endtask

    // Steps from zero until an event pulse; returns the step count.
    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            step();
            n++;
            if (rst_req_o || nmi_o) break;
        end
    endtask

    function automatic int period_of(input int code);
        return TPB << ((code > PSMAX) ? PSMAX : code);
    endfunction

    function automatic int thr_of(input int p, input int sz);
        int e;
        e = (sz == 3) ? 2 : (sz == 2) ? 3 : (sz == 1) ? 4 : 6;
        return p - (p * e) / 8;
    endfunction

    initial begin
        int n;
        int p;
        int t;
        do_reset();
        // Reset state under the force strap.
        chk("R9 en_o after reset", en_o, 1);
        chk("R8 count after reset", count_o, 0);
        chk("R6 no pulse after reset", {timeout_o, rst_req_o, nmi_o, win_err_o}, 0);

        // R1 / R2: sweep every postscaler code, awake, no window.
        for (int c = 0; c < 32; c++) begin
            strap_ps_i = 5'(c);
            do_reset();
            measure(n);
            if (c <= PSMAX) chk($sformatf("R1 period code %0d", c), n, period_of(c));
            else            chk($sformatf("R2 period code %0d", c), n, period_of(PSMAX));
        end

        // R6: single-cycle pulse and restart after awake expiry.
        strap_ps_i = 5'd2;
        do_reset();
        measure(n);
        chk("R6 timeout_o", timeout_o, 1);
        chk("R6 nmi_o low", nmi_o, 0);
        chk("R6 count restart", count_o, 0);
        step();
        chk("R6 pulse ends", {timeout_o, rst_req_o}, 0);
        chk("R6 counts again", count_o, 1);

        // R7: expiry in sleep and in idle.
        do_reset();
        sleep_i = 1'b1;
        measure(n);
        chk("R7 nmi in sleep", nmi_o, 1);
        chk("R7 no reset in sleep", rst_req_o, 0);
        sleep_i = 1'b0;
        do_reset();
        idle_i = 1'b1;
        measure(n);
        chk("R7 nmi in idle", nmi_o, 1);
        chk("R7 no reset in idle", rst_req_o, 0);
        idle_i = 1'b0;

        // R3 / R4: every window size, clear just before and at the threshold.
        strap_ps_i = 5'd3;
        strap_win_en_i = 1'b1;
        p = period_of(3);
        for (int sz = 0; sz < 4; sz++) begin
            strap_win_size_i = 2'(sz);
            t = thr_of(p, sz);
            do_reset();
            chk("R11 strap window", win_mode_o, 1);
            steps(t - 1);
            pulse_clr();
            chk($sformatf("R4 early clear size %0d win_err", sz), win_err_o, 1);
            chk($sformatf("R4 early clear size %0d rst_req", sz), rst_req_o, 1);
            chk($sformatf("R4 early clear size %0d count", sz), count_o, 0);
            step();
            chk("R4 pulse one cycle", {win_err_o, rst_req_o}, 0);
            do_reset();
            steps(t);
            pulse_clr();
            chk($sformatf("R3 window clear size %0d pulses", sz),
                {win_err_o, rst_req_o, timeout_o}, 0);
            chk($sformatf("R3 window clear size %0d count", sz), count_o, 0);
        end
        strap_win_en_i = 1'b0;

        // R5: clear outside window mode at a small count.
        do_reset();
        steps(5);
        pulse_clr();
        chk("R5 early clear no pulse", {win_err_o, rst_req_o}, 0);
        chk("R5 early clear zeroes", count_o, 0);

        // R8: debug clear, interrupt wake, and sleep entry.
        steps(6);
        dbg_clr_i = 1'b1; step(); dbg_clr_i = 1'b0;
        chk("R8 debug clear", count_o, 0);
        steps(6);
        irq_wake_i = 1'b1; step(); irq_wake_i = 1'b0;
        chk("R8 interrupt wake clear", count_o, 0);
        steps(5);
        sleep_i = 1'b1; step();
        chk("R8 sleep entry keeps count", count_o, 6);
        sleep_i = 1'b0;

        // R12: debug holds the count past a whole period.
        debug_i = 1'b1;
        steps(p + 4);
        chk("R12 count held", count_o, 6);
        chk("R12 no timeout", {timeout_o, rst_req_o, nmi_o}, 0);
        debug_i = 1'b0;
        step();
        chk("R12 resumes", count_o, 7);

        // R9: software cannot turn off a forced watchdog.
        write_cfg(1'b0, 1'b0);
        chk("R9 forced on", en_o, 1);

        // R10: software enable.
        strap_force_en_i = 1'b0;
        do_reset();
        chk("R10 enable resets 0", en_o, 0);
        steps(p + 3);
        chk("R10 disabled count", count_o, 0);
        chk("R10 disabled no pulse", {timeout_o, rst_req_o, nmi_o}, 0);
        write_cfg(1'b1, 1'b0);
        chk("R10 enabled by write", en_o, 1);
        steps(3);
        chk("R10 counting", count_o, 3);
        measure(n);
        chk("R10 period once enabled", n, p - 3);
        do_reset();
        chk("R10 enable cleared by reset", en_o, 0);

        // R11: software window bit.
        chk("R11 window bit reset", win_mode_o, 0);
        write_cfg(1'b1, 1'b1);
        chk("R11 window by software", win_mode_o, 1);
        steps(2);
        pulse_clr();
        chk("R11 early clear faults", win_err_o, 1);
        write_cfg(1'b1, 1'b0);
        chk("R11 window off", win_mode_o, 0);
        steps(2);
        pulse_clr();
        chk("R11 early clear accepted", win_err_o, 0);

        summary();
    end
endmodule